// File: doc/BRIEF.md
# Block-Transfer Host Register Port

This block is the host-facing side of a block-transfer management mailbox. The host sees three byte-wide registers behind a two-bit offset: a control/status register, a data port and a mask register. Writing the data port appends bytes to a request buffer. Reading it drains a response buffer. Control writes are commands: they rewind either buffer pointer, acknowledge attention flags, flip the host-busy flag, or hand the finished request to the controller side.

The controller side reads the request bytes through a read port and sees the request length. It fills the response buffer through a write port, then commits it with a load strobe that gives the response length. It can also raise the system-software attention flag. The stored control flags and the mask byte are brought out so that a separate block can decode messages and raise interrupts.

Top module: `bt_host_port`

## Requirements
- R1: Offset 0 selects control, offset 1 the data port and offset 2 the mask register. A read at offset 3 returns 0xFF. A write at offset 3 changes no state.
- R2: A control read returns controller-to-host attention in bit 3, system-software attention in bit 4, host-busy in bit 6 and controller-busy in bit 7. Bits 0, 1, 2 and 5 read as 0. `ctrl_q` carries the same byte.
- R3: A control write with bit 0 set makes the request length 0. A control write with bit 1 set moves the response read index back to 0.
- R4: A control write with bit 3 set clears controller-to-host attention, and bit 4 set clears system-software attention. Writing 0 to these bits leaves them unchanged.
- R5: A control write with bit 6 set inverts host-busy. Writing 0 to bit 6 leaves host-busy unchanged.
- R6: A control write with bit 2 set sets controller-busy and drives `req_ready` high for exactly the following cycle.
- R7: A data-port write stores the byte at the current request length when that length is below BUF_BYTES. The length then increments even when the byte is dropped, and stops at 2^LEN_W-1.
- R8: A data-port read returns the response byte at the read index and advances the index while the index is below the response length. Otherwise the read returns 0xFF and nothing moves.
- R9: The read that consumes the last response byte returns both the read index and the response length to 0.
- R10: `rsp_load` clears controller-busy, sets controller-to-host attention, rewinds the read index and sets the response length to min(`rsp_load_len`, BUF_BYTES). `sms_set` sets system-software attention.
- R11: A mask write stores the byte. Mask reads and `mask_q` return the stored byte.
- R12: After reset, the request length, read index, response length, all control flags and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on the data port) |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the current offset |
| req_ready | output | 1 | One-cycle request handoff pulse |
| req_len | output | LEN_W | Request length, saturating |
| req_rd_addr | input | AW | Request buffer read address |
| req_rd_data | output | 8 | Request byte at req_rd_addr |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_wr_addr | input | AW | Response buffer write address |
| rsp_wr_data | input | 8 | Response buffer write byte |
| rsp_load | input | 1 | Commit response and update flags |
| rsp_load_len | input | RSP_W | Committed response length |
| sms_set | input | 1 | Raise system-software attention |
| ctrl_q | output | 8 | Stored control/status byte |
| mask_q | output | 8 | Stored mask byte |

## Verification
The assertions assume that the host never asserts a read and a write in the same cycle. They also assume that a response load and a host control write never fall in the same cycle, because the load's effect on controller-busy and the read index would then take priority. The stimulus drives one operation per cycle from a single task, so both conditions hold by construction. Response bytes are only written while the host is not reading the data port.

// File: rtl/bt_host_port.sv
module bt_host_port #(
  parameter int BUF_BYTES = 64,
  parameter int AW        = $clog2(BUF_BYTES),
  parameter int LEN_W     = AW + 2,
  parameter int RSP_W     = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [1:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             req_ready,
  output logic [LEN_W-1:0] req_len,
  input  logic [AW-1:0]    req_rd_addr,
  output logic [7:0]       req_rd_data,
  input  logic             rsp_wr,
  input  logic [AW-1:0]    rsp_wr_addr,
  input  logic [7:0]       rsp_wr_data,
  input  logic             rsp_load,
  input  logic [RSP_W-1:0] rsp_load_len,
  input  logic             sms_set,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       mask_q
);
  localparam logic [RSP_W-1:0] BUF_CAP = RSP_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] LEN_LIM = LEN_W'(BUF_BYTES);

  logic [7:0]       req_mem [BUF_BYTES];
  logic [7:0]       rsp_mem [BUF_BYTES];
  logic [RSP_W-1:0] rsp_idx, rsp_len;
  logic             b2h, sms, hbusy, bbusy;
  logic [7:0]       mask_r;

  wire ctl_wr   = host_wr && host_addr == 2'd0;
  wire dat_wr   = host_wr && host_addr == 2'd1;
  wire msk_wr   = host_wr && host_addr == 2'd2;
  wire dat_rd   = host_rd && host_addr == 2'd1;
  wire avail    = rsp_idx < rsp_len;
  wire [RSP_W-1:0] idx_nx   = rsp_idx + 1'b1;
  wire [RSP_W-1:0] load_len = (rsp_load_len > BUF_CAP) ? BUF_CAP : rsp_load_len;

  assign ctrl_q      = {bbusy, hbusy, 1'b0, sms, b2h, 3'b000};
  assign mask_q      = mask_r;
  assign req_rd_data = req_mem[req_rd_addr];

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = ctrl_q;
      2'd1:    host_rdata = avail ? rsp_mem[rsp_idx[AW-1:0]] : 8'hFF;
      2'd2:    host_rdata = mask_r;
      default: host_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dat_wr && req_len < LEN_LIM) req_mem[req_len[AW-1:0]] <= host_wdata;
    if (rsp_wr) rsp_mem[rsp_wr_addr] <= rsp_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_len   <= '0;
      rsp_idx   <= '0;
      rsp_len   <= '0;
      b2h       <= 1'b0;
      sms       <= 1'b0;
      hbusy     <= 1'b0;
      bbusy     <= 1'b0;
      mask_r    <= '0;
      req_ready <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      if (ctl_wr) begin
        if (host_wdata[0]) req_len <= '0;
        if (host_wdata[1]) rsp_idx <= '0;
        if (host_wdata[3]) b2h <= 1'b0;
        if (host_wdata[4]) sms <= 1'b0;
        if (host_wdata[6]) hbusy <= ~hbusy;
        if (host_wdata[2]) begin
          bbusy     <= 1'b1;
          req_ready <= 1'b1;
        end
      end
      if (dat_wr && req_len != '1) req_len <= req_len + 1'b1;
      if (msk_wr) mask_r <= host_wdata;
      if (dat_rd && avail) begin
        if (idx_nx == rsp_len) begin
          rsp_idx <= '0;
          rsp_len <= '0;
        end else begin
          rsp_idx <= idx_nx;
        end
      end
      if (rsp_load) begin
        rsp_len <= load_len;
        rsp_idx <= '0;
        bbusy   <= 1'b0;
        b2h     <= 1'b1;
      end
      if (sms_set) sms <= 1'b1;
    end
  end
endmodule

module bt_host_port_chk #(
  parameter int LEN_W = 8,
  parameter int RSP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic [7:0]       host_rdata,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             rsp_load,
  input logic [7:0]       ctrl_q,
  input logic [RSP_W-1:0] rsp_idx,
  input logic [RSP_W-1:0] rsp_len
);
  a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_rd));
  a_r1_off3_ff: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd3 |-> host_rdata == 8'hFF);
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd0 && host_wdata[2] && !rsp_load |=> req_ready && ctrl_q[7]);
  a_r7_len_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 2'd1 |=> req_len >= $past(req_len) && req_len != '0);
  a_r8_empty_ff: assert property (@(posedge clk) disable iff (!rst_n)
    host_addr == 2'd1 && rsp_idx >= rsp_len |-> host_rdata == 8'hFF);
  a_r9_drain_clear: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && host_addr == 2'd1 && rsp_idx < rsp_len &&
    (RSP_W+1)'(rsp_idx) + 1 == (RSP_W+1)'(rsp_len) && !rsp_load
    |=> rsp_len == '0 && rsp_idx == '0);
  a_r10_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load |=> !ctrl_q[7] && ctrl_q[3] && rsp_idx == '0);
endmodule

bind bt_host_port bt_host_port_chk #(.LEN_W(LEN_W), .RSP_W(RSP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .req_ready(req_ready), .req_len(req_len), .rsp_load(rsp_load),
  .ctrl_q(ctrl_q), .rsp_idx(rsp_idx), .rsp_len(rsp_len)
);

// File: tb/bt_host_port_test.sv
`timescale 1ns/1ps
module bt_host_port_test;
  localparam int BUF = 64;
  localparam int LMAX = 255;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, rsp_wr = 0, rsp_load = 0, sms_set = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, rsp_wr_data = 0;
  logic [5:0] req_rd_addr = 0, rsp_wr_addr = 0;
  logic [6:0] rsp_load_len = 0;
  logic [7:0] host_rdata, req_rd_data, ctrl_q, mask_q;
  logic [7:0] req_len;
  logic req_ready;

  bt_host_port uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_req_len = 0, m_idx = 0, m_rsp_len = 0;
  bit m_b2h = 0, m_sms = 0, m_hbusy = 0, m_bbusy = 0, m_pulse = 0;
  logic [7:0] m_mask = 0;
  logic [7:0] m_req [BUF];
  logic [7:0] m_rsp [BUF];

  function automatic logic [7:0] m_ctrl();
    return {m_bbusy, m_hbusy, 1'b0, m_sms, m_b2h, 3'b000};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, bit rd, logic [1:0] a, logic [7:0] d,
                      bit ld = 0, int ldlen = 0, bit ss = 0,
                      bit rw = 0, int ra = 0, logic [7:0] rdat = 0);
    logic [7:0] exp_rd;
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
    rsp_load = ld; rsp_load_len = 7'(ldlen); sms_set = ss;
    rsp_wr = rw; rsp_wr_addr = 6'(ra); rsp_wr_data = rdat;
    #1;
    case (a)
      2'd0: exp_rd = m_ctrl();
      2'd1: exp_rd = (m_idx < m_rsp_len) ? m_rsp[m_idx] : 8'hFF;
      2'd2: exp_rd = m_mask;
      default: exp_rd = 8'hFF;
    endcase
    if (rd) chk(tag, "host_rdata", host_rdata, exp_rd);
    @(posedge clk);
    m_pulse = 0;
    if (rw) m_rsp[ra] = rdat;
    if (wr) begin
      case (a)
        2'd0: begin
          if (d[0]) m_req_len = 0;
          if (d[1]) m_idx = 0;
          if (d[3]) m_b2h = 0;
          if (d[4]) m_sms = 0;
          if (d[6]) m_hbusy = !m_hbusy;
          if (d[2]) begin m_bbusy = 1; m_pulse = 1; end
        end
        2'd1: begin
          if (m_req_len < BUF) m_req[m_req_len] = d;
          if (m_req_len < LMAX) m_req_len++;
        end
        2'd2: m_mask = d;
        default: ;
      endcase
    end
    if (rd && a == 2'd1 && m_idx < m_rsp_len) begin
      m_idx++;
      if (m_idx == m_rsp_len) begin m_idx = 0; m_rsp_len = 0; end
    end
    if (ld) begin
      m_rsp_len = (ldlen > BUF) ? BUF : ldlen;
      m_idx = 0; m_bbusy = 0; m_b2h = 1;
    end
    if (ss) m_sms = 1;
    #1;
    host_wr = 0; host_rd = 0; rsp_load = 0; sms_set = 0; rsp_wr = 0;
    chk(tag, "req_len", req_len, m_req_len);
    chk(tag, "ctrl_q", ctrl_q, m_ctrl());
    chk(tag, "mask_q", mask_q, m_mask);
    chk(tag, "req_ready", req_ready, m_pulse);
  endtask

  task automatic chk_req(string tag, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_rd_addr = 6'(i);
      #1 chk(tag, "req_rd_data", req_rd_data, m_req[i]);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R12 reset state
    step("R12", 0, 1, 2'd0, 0);
    step("R12", 0, 1, 2'd1, 0);
    step("R12", 0, 1, 2'd2, 0);
    // R11 mask, R1 offset 3
    step("R11", 1, 0, 2'd2, 8'hA5);
    step("R11", 0, 1, 2'd2, 0);
    step("R1", 1, 0, 2'd3, 8'hFF);
    step("R1", 0, 1, 2'd3, 0);
    step("R1", 0, 1, 2'd0, 0);
    // R7 request bytes
    for (int i = 0; i < 5; i++) step("R7", 1, 0, 2'd1, 8'(8'h30 + i));
    chk_req("R7", 5);
    // R6 handoff
    step("R6", 1, 0, 2'd0, 8'h04);
    step("R6", 0, 0, 2'd0, 0);
    // R5 toggle
    step("R5", 1, 0, 2'd0, 8'h40);
    step("R5", 1, 0, 2'd0, 8'h00);
    step("R5", 0, 1, 2'd0, 0);
    step("R5", 1, 0, 2'd0, 8'h40);
    // R4 attention clears
    step("R10", 0, 0, 2'd0, 0, 0, 0, 1);
    step("R4", 1, 0, 2'd0, 8'h00);
    step("R2", 0, 1, 2'd0, 0);
    step("R4", 1, 0, 2'd0, 8'h10);
    // R10 response load
    for (int i = 0; i < 4; i++) step("R10", 0, 0, 2'd0, 0, 0, 0, 0, 1, i, 8'(8'hC0 + i));
    step("R10", 0, 0, 2'd0, 0, 1, 4);
    step("R2", 0, 1, 2'd0, 0);
    // R8 partial read, R3 rewind
    step("R8", 0, 1, 2'd1, 0);
    step("R8", 0, 1, 2'd1, 0);
    step("R3", 1, 0, 2'd0, 8'h02);
    for (int i = 0; i < 4; i++) step("R8", 0, 1, 2'd1, 0);
    // R9 drained
    step("R9", 0, 1, 2'd1, 0);
    step("R9", 1, 0, 2'd0, 8'h02);
    step("R9", 0, 1, 2'd1, 0);
    step("R4", 1, 0, 2'd0, 8'h08);
    // R10 clamp to BUF
    for (int i = 0; i < BUF; i++) step("R10", 0, 0, 2'd0, 0, 0, 0, 0, 1, i, 8'(i * 3 + 1));
    step("R10", 0, 0, 2'd0, 0, 1, 100);
    for (int i = 0; i < BUF + 2; i++) step("R8", 0, 1, 2'd1, 0);
    // R3 clear write pointer, R7 overrun and saturation
    step("R3", 1, 0, 2'd0, 8'h01);
    for (int i = 0; i < 70; i++) step("R7", 1, 0, 2'd1, 8'(i ^ 8'h5A));
    chk_req("R7", BUF);
    for (int i = 0; i < 200; i++) step("R7", 1, 0, 2'd1, 8'h11);
    step("R3", 1, 0, 2'd0, 8'h01);
    step("R11", 0, 1, 2'd2, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule